// File: doc/BRIEF.md
# Branch Target Predictor with Return Address Stack

This block sits in an instruction fetch front end and guesses where fetch goes next. Each fetch address is compared, in the same cycle, against a small fully associative table of previously resolved control-flow instructions. On a hit the table supplies a target address, the slot number that matched and a kind code. The kind code says whether the instruction is a conditional branch, a plain jump, a call or a return. For a return, the target comes from a return address stack instead of the table. That stack is maintained speculatively at fetch time: a call hit pushes the sequential address, and a return hit pops it.

The execution side keeps the table current through a resolve port. Each resolved instruction arrives with its address, its target, its destination and source register numbers, and the slot it was predicted from. If the slot number is out of range, the resolve is treated as a miss, and a slot is taken from a round-robin replacement pointer. This is how a redirect that the table did not predict gets learned. The kind is derived from the register numbers using the usual link-register convention.

Top module: `btb_ras_predictor`

## Requirements
- R1: With `fetchValid` high, a fetch address hits when some valid slot holds a tag equal to its low `TAG_BITS` bits. If several slots match, the lowest-numbered slot wins. On a hit, `predHit` is 1, `predEntry` is the slot number, and `predKind` and the target come from that slot, all combinationally in the same cycle. On a miss, `predHit` and `predValid` are 0, `predKind` is 0, `predEntry` equals `ENTRIES`, and `predNextPc` is `fetchPc + INSN_BYTES`. With `fetchValid` low, the outputs are those of a miss.
- R2: Only bits `TAG_BITS-1:0` of the fetch address take part in the compare. Addresses that differ only above them hit the same slot, and a difference in bit `TAG_BITS-1` misses.
- R3: A resolve with `updEntry < ENTRIES` overwrites that slot. The new contents are seen by lookups from the next cycle on, and a lookup in the same cycle still sees the old contents.
- R4: A resolve with `updEntry >= ENTRIES` writes the slot named by a replacement pointer, then advances the pointer by one. The pointer is 0 after reset and wraps from `ENTRIES-1` to 0, whatever the value of `ENTRIES`.
- R5: Each slot stores a kind code, set from the resolve inputs in this order. A resolve with `updCond` high stores 0, a conditional branch. Otherwise a destination register of 1 or 5 stores 2, a call. Otherwise, an indirect jump (`updIndirect`) whose source register is 1 or 5 stores 3, a return. Anything else stores 1, a plain jump.
- R6: An indirect jump reading and writing register 1, resolved with `updAuipcPair` high, stores kind 1 rather than kind 2, so it never pushes the stack.
- R7: A fetch hit on kind 2 pushes `fetchPc + INSN_BYTES` onto the return stack at the clock edge ending that cycle, and predicts the slot target. A fetch hit on kind 3 with a non-empty stack predicts the top of the stack and pops it.
- R8: The stack holds `RAS_DEPTH` addresses. A push when the stack is full overwrites the oldest address, so the most recent `RAS_DEPTH` pushes are returned newest first.
- R9: A fetch hit on kind 3 with an empty stack reports `predHit` 1 and kind 3, but `predValid` is 0, `predNextPc` is `fetchPc + INSN_BYTES`, and the stack is unchanged.
- R10: After reset no slot is valid, the stack is empty and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch address is valid this cycle |
| fetchPc | input | PC_W | Fetch address |
| predHit | output | 1 | Table hit |
| predValid | output | 1 | `predNextPc` is a prediction |
| predEntry | output | IDX_W | Matching slot, or `ENTRIES` on a miss |
| predKind | output | 2 | Kind code of the matching slot |
| predNextPc | output | PC_W | Predicted next fetch address |
| updValid | input | 1 | Resolve strobe |
| updPc | input | PC_W | Address of the resolved instruction |
| updTarget | input | PC_W | Resolved target |
| updEntry | input | IDX_W | Slot the instruction was predicted from; `>= ENTRIES` means none |
| updCond | input | 1 | Resolved instruction is a conditional branch |
| updIndirect | input | 1 | Resolved jump takes its target from a register |
| updRd | input | REG_W | Destination register number |
| updRs1 | input | REG_W | Source register number of an indirect jump |
| updAuipcPair | input | 1 | The jump directly follows a PC-relative upper-immediate add into register 1 |

## Verification
A corrupted slot shows up at the next fetch that matches it, as a wrong target, kind or slot number on that same cycle. A replacement pointer that is off by one only shows later, when a resolve lands in the wrong slot and a later lookup misses or names the wrong slot. A wrong stack pointer or fill count becomes visible at the next return hit. There it gives a stale address, or a prediction where none is allowed, so the bench compares every output against a behavioural model on every cycle and walks the stack through both overflow and underflow.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_CALL = 2'd2,
    KIND_RET  = 2'd3
  } brKind_e;

  typedef struct packed {
    logic wrEn;
    logic rasPush;
    logic rasPop;
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 8,
  parameter int TAG_BITS  = 14,
  parameter int RAS_DEPTH = 6,
  parameter int SLOT_W    = 3,
  parameter int RAS_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TAG_BITS-1:0]  fetchTag,
  input  btbStrobe_t           ctl,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic [TAG_BITS-1:0]  wrTag,
  input  logic [PC_W-1:0]      wrTarget,
  input  brKind_e              wrKind,
  input  logic [RAS_IDX_W-1:0] rasWrIdx,
  input  logic [PC_W-1:0]      rasWrData,
  input  logic [RAS_IDX_W-1:0] rasRdIdx,
  output logic                 lkHit,
  output logic [SLOT_W-1:0]    lkSlot,
  output logic [PC_W-1:0]      lkTarget,
  output brKind_e              lkKind,
  output logic [PC_W-1:0]      rasTopData
);

  logic [ENTRIES-1:0]  validQ;
  logic [TAG_BITS-1:0] tagQ    [ENTRIES];
  logic [PC_W-1:0]     targetQ [ENTRIES];
  brKind_e             kindQ   [ENTRIES];
  logic [PC_W-1:0]     rasQ    [RAS_DEPTH];
  logic [ENTRIES-1:0]  matchVec;

  // one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (tagQ[g] == fetchTag);
  end

  // lowest matching slot wins
  always_comb begin
    lkSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) lkSlot = SLOT_W'(i);
    end
  end

  assign lkHit      = |matchVec;
  assign lkTarget   = targetQ[lkSlot];
  assign lkKind     = kindQ[lkSlot];
  assign rasTopData = rasQ[rasRdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (ctl.wrEn) validQ[wrSlot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      tagQ[wrSlot]    <= wrTag;
      targetQ[wrSlot] <= wrTarget;
      kindQ[wrSlot]   <= wrKind;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.rasPush) rasQ[rasWrIdx] <= rasWrData;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> validQ[$past(wrSlot)] && tagQ[$past(wrSlot)] == $past(wrTag)
                 && targetQ[$past(wrSlot)] == $past(wrTarget)); // R3

  AST_POP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rasPop && !ctl.rasPush |=> rasQ[$past(rasRdIdx)] == $past(rasTopData)); // R7

endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 8,
  parameter int RAS_DEPTH  = 6,
  parameter int INSN_BYTES = 4,
  parameter int REG_W      = 5,
  parameter int SLOT_W     = 3,
  parameter int IDX_W      = 4,
  parameter int RAS_IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [PC_W-1:0]      fetchPc,
  input  logic                 lkHit,
  input  logic [SLOT_W-1:0]    lkSlot,
  input  logic [PC_W-1:0]      lkTarget,
  input  brKind_e              lkKind,
  input  logic [PC_W-1:0]      rasTopData,
  input  logic                 updValid,
  input  logic [IDX_W-1:0]     updEntry,
  input  logic                 updCond,
  input  logic                 updIndirect,
  input  logic [REG_W-1:0]     updRd,
  input  logic [REG_W-1:0]     updRs1,
  input  logic                 updAuipcPair,
  output btbStrobe_t           ctl,
  output logic [SLOT_W-1:0]    wrSlot,
  output brKind_e              wrKind,
  output logic [RAS_IDX_W-1:0] rasWrIdx,
  output logic [PC_W-1:0]      rasWrData,
  output logic [RAS_IDX_W-1:0] rasRdIdx,
  output logic                 predHit,
  output logic                 predValid,
  output logic [IDX_W-1:0]     predEntry,
  output logic [1:0]           predKind,
  output logic [PC_W-1:0]      predNextPc
);

  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam logic [IDX_W-1:0]     ENTRY_LIMIT = IDX_W'(ENTRIES);
  localparam logic [SLOT_W-1:0]    LAST_SLOT   = SLOT_W'(ENTRIES - 1);
  localparam logic [RAS_IDX_W-1:0] LAST_RAS    = RAS_IDX_W'(RAS_DEPTH - 1);
  localparam logic [CNT_W-1:0]     RAS_FULL    = CNT_W'(RAS_DEPTH);
  localparam logic [REG_W-1:0]     LINK_A      = REG_W'(1);
  localparam logic [REG_W-1:0]     LINK_B      = REG_W'(5);

  logic [SLOT_W-1:0]    fifoQ;
  logic [RAS_IDX_W-1:0] rasTopQ;
  logic [CNT_W-1:0]     rasCntQ;

  logic fetchHit, rasEmpty, isRet, isCall, retNoPred, allocate;
  logic rdLink, rsLink, pairSkip;
  logic [PC_W-1:0]      seqPc;
  logic [RAS_IDX_W-1:0] rasNext, rasPrev;

  // fetch side
  assign fetchHit  = fetchValid && lkHit;
  assign rasEmpty  = (rasCntQ == '0);
  assign isRet     = (lkKind == KIND_RET);
  assign isCall    = (lkKind == KIND_CALL);
  assign retNoPred = isRet && rasEmpty;
  assign seqPc     = fetchPc + PC_W'(INSN_BYTES);
  assign rasNext   = (rasTopQ == LAST_RAS) ? '0 : rasTopQ + 1'b1;
  assign rasPrev   = (rasTopQ == '0) ? LAST_RAS : rasTopQ - 1'b1;

  assign ctl.rasPush = fetchHit && isCall;
  assign ctl.rasPop  = fetchHit && isRet && !rasEmpty;
  assign rasWrIdx    = rasNext;
  assign rasWrData   = seqPc;
  assign rasRdIdx    = rasTopQ;

  assign predHit    = fetchHit;
  assign predValid  = fetchHit && !retNoPred;
  assign predEntry  = fetchHit ? {1'b0, lkSlot} : ENTRY_LIMIT;
  assign predKind   = fetchHit ? lkKind : KIND_COND;
  assign predNextPc = predValid ? (isRet ? rasTopData : lkTarget) : seqPc;

  // resolve side
  assign allocate   = !(updEntry < ENTRY_LIMIT);
  assign ctl.wrEn   = updValid;
  assign wrSlot     = allocate ? fifoQ : updEntry[SLOT_W-1:0];
  assign rdLink     = (updRd == LINK_A) || (updRd == LINK_B);
  assign rsLink     = (updRs1 == LINK_A) || (updRs1 == LINK_B);
  assign pairSkip   = updAuipcPair && updIndirect && (updRd == LINK_A) && (updRs1 == LINK_A);

  always_comb begin
    if (updCond)                           wrKind = KIND_COND;
    else if (rdLink && !pairSkip)          wrKind = KIND_CALL;
    else if (updIndirect && rsLink && !rdLink) wrKind = KIND_RET;
    else                                   wrKind = KIND_JUMP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoQ <= '0;
    end else if (updValid && allocate) begin
      fifoQ <= (fifoQ == LAST_SLOT) ? '0 : fifoQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasTopQ <= LAST_RAS;
      rasCntQ <= '0;
    end else if (ctl.rasPush) begin
      rasTopQ <= rasNext;
      if (rasCntQ != RAS_FULL) rasCntQ <= rasCntQ + 1'b1;
    end else if (ctl.rasPop) begin
      rasTopQ <= rasPrev;
      rasCntQ <= rasCntQ - 1'b1;
    end
  end

  AST_FIFO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    updValid && allocate |=> fifoQ == (($past(fifoQ) == LAST_SLOT) ? '0 : $past(fifoQ) + 1'b1)); // R4

  AST_RAS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rasCntQ <= RAS_FULL); // R8

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rasPush && rasCntQ != RAS_FULL |=> rasCntQ == $past(rasCntQ) + 1'b1); // R7

  AST_EMPTY_RET_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && lkHit && isRet && rasCntQ == '0 |-> !predValid && predNextPc == fetchPc + PC_W'(INSN_BYTES)); // R9

  AST_EMPTY_RET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && lkHit && isRet && rasCntQ == '0 |=> rasCntQ == '0 || $past(ctl.rasPush)); // R9

endmodule

// File: rtl/btb_ras_predictor.sv
module btb_ras_predictor
  import btb_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 8,
  parameter int TAG_BITS   = 14,
  parameter int RAS_DEPTH  = 6,
  parameter int INSN_BYTES = 4,
  parameter int REG_W      = 5,
  localparam int SLOT_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int IDX_W     = SLOT_W + 1,
  localparam int RAS_IDX_W = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predHit,
  output logic             predValid,
  output logic [IDX_W-1:0] predEntry,
  output logic [1:0]       predKind,
  output logic [PC_W-1:0]  predNextPc,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  logic [IDX_W-1:0] updEntry,
  input  logic             updCond,
  input  logic             updIndirect,
  input  logic [REG_W-1:0] updRd,
  input  logic [REG_W-1:0] updRs1,
  input  logic             updAuipcPair
);

  btbStrobe_t           ctl;
  logic                 lkHit;
  logic [SLOT_W-1:0]    lkSlot, wrSlot;
  logic [PC_W-1:0]      lkTarget, rasTopData, rasWrData;
  brKind_e              lkKind, wrKind;
  logic [RAS_IDX_W-1:0] rasWrIdx, rasRdIdx;

  btb_datapath #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_BITS(TAG_BITS),
    .RAS_DEPTH(RAS_DEPTH), .SLOT_W(SLOT_W), .RAS_IDX_W(RAS_IDX_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN),
    .fetchTag(fetchPc[TAG_BITS-1:0]),
    .ctl(ctl), .wrSlot(wrSlot),
    .wrTag(updPc[TAG_BITS-1:0]), .wrTarget(updTarget), .wrKind(wrKind),
    .rasWrIdx(rasWrIdx), .rasWrData(rasWrData), .rasRdIdx(rasRdIdx),
    .lkHit(lkHit), .lkSlot(lkSlot), .lkTarget(lkTarget), .lkKind(lkKind),
    .rasTopData(rasTopData)
  );

  btb_control #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .RAS_DEPTH(RAS_DEPTH),
    .INSN_BYTES(INSN_BYTES), .REG_W(REG_W), .SLOT_W(SLOT_W),
    .IDX_W(IDX_W), .RAS_IDX_W(RAS_IDX_W)
  ) uControl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .lkHit(lkHit), .lkSlot(lkSlot), .lkTarget(lkTarget), .lkKind(lkKind),
    .rasTopData(rasTopData),
    .updValid(updValid), .updEntry(updEntry), .updCond(updCond),
    .updIndirect(updIndirect), .updRd(updRd), .updRs1(updRs1),
    .updAuipcPair(updAuipcPair),
    .ctl(ctl), .wrSlot(wrSlot), .wrKind(wrKind),
    .rasWrIdx(rasWrIdx), .rasWrData(rasWrData), .rasRdIdx(rasRdIdx),
    .predHit(predHit), .predValid(predValid), .predEntry(predEntry),
    .predKind(predKind), .predNextPc(predNextPc)
  );

  AST_UPD_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> !$isunknown(updPc)); // R3

endmodule

// File: tb/btb_ras_predictor_test.sv
module btb_ras_predictor_test;

  localparam int E     = 8;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid;
  logic [31:0] fetchPc;
  logic        predHit, predValid;
  logic [3:0]  predEntry;
  logic [1:0]  predKind;
  logic [31:0] predNextPc;
  logic        updValid;
  logic [31:0] updPc, updTarget;
  logic [3:0]  updEntry;
  logic        updCond, updIndirect, updAuipcPair;
  logic [4:0]  updRd, updRs1;

  int total = 0;
  int bad   = 0;

  bit          mValid [E];
  logic [13:0] mTag   [E];
  logic [31:0] mTgt   [E];
  int          mKind  [E];
  int          mFifo;
  logic [31:0] mRas [$];

  always #5 clk = ~clk;

  btb_ras_predictor uut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predHit(predHit), .predValid(predValid), .predEntry(predEntry),
    .predKind(predKind), .predNextPc(predNextPc),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget),
    .updEntry(updEntry), .updCond(updCond), .updIndirect(updIndirect),
    .updRd(updRd), .updRs1(updRs1), .updAuipcPair(updAuipcPair)
  );

  function automatic int classify(bit c, bit ind, int rd, int rs, bit pair);
    bit rl = (rd == 1) || (rd == 5);
    bit sl = (rs == 1) || (rs == 5);
    if (c) return 0;
    if (pair && ind && rd == 1 && rs == 1) return 1;
    if (rl) return 2;
    if (ind && sl) return 3;
    return 1;
  endfunction

  task automatic idle();
    fetchValid = 0; fetchPc = 0; updValid = 0; updPc = 0; updTarget = 0;
    updEntry = 0; updCond = 0; updIndirect = 0; updRd = 0; updRs1 = 0; updAuipcPair = 0;
  endtask

  task automatic setFetch(logic [31:0] pc);
    fetchValid = 1; fetchPc = pc;
  endtask

  task automatic setUpd(logic [31:0] pc, logic [31:0] tgt, int ent, bit c, bit ind,
                        int rd, int rs, bit pair);
    updValid = 1; updPc = pc; updTarget = tgt; updEntry = 4'(ent);
    updCond = c; updIndirect = ind; updRd = 5'(rd); updRs1 = 5'(rs); updAuipcPair = pair;
  endtask

  // compare one cycle against the model, then advance the model over the edge
  task automatic cycle(string tag);
    bit eHit = 0, eValid;
    int eIdx = E, eKind = 0;
    logic [31:0] eNext, eTgt;
    #1;
    if (fetchValid) begin
      for (int i = 0; i < E; i++) begin
        if (!eHit && mValid[i] && mTag[i] == fetchPc[13:0]) begin
          eHit = 1; eIdx = i;
        end
      end
    end
    if (eHit) eKind = mKind[eIdx];
    eValid = eHit && !(eKind == 3 && mRas.size() == 0);
    eTgt   = (eHit && eKind == 3 && mRas.size() > 0) ? mRas[$] : (eHit ? mTgt[eIdx] : 32'h0);
    eNext  = eValid ? eTgt : fetchPc + 32'd4;
    total++;
    if (predHit !== eHit || predValid !== eValid || predEntry !== 4'(eIdx) ||
        predKind !== 2'(eKind) || predNextPc !== eNext) begin
      bad++;
      $display("FAIL %s pc=%h got hit=%0b val=%0b ent=%0d kind=%0d next=%h exp hit=%0b val=%0b ent=%0d kind=%0d next=%h",
               tag, fetchPc, predHit, predValid, predEntry, predKind, predNextPc,
               eHit, eValid, eIdx, eKind, eNext);
    end
    @(posedge clk);
    if (eHit && eKind == 2) begin
      mRas.push_back(fetchPc + 32'd4);
      if (mRas.size() > DEPTH) void'(mRas.pop_front());
    end else if (eHit && eKind == 3 && mRas.size() > 0) begin
      void'(mRas.pop_back());
    end
    if (updValid) begin
      int s;
      if (int'(updEntry) < E) s = int'(updEntry);
      else begin s = mFifo; mFifo = (mFifo + 1) % E; end
      mValid[s] = 1; mTag[s] = updPc[13:0]; mTgt[s] = updTarget;
      mKind[s] = classify(updCond, updIndirect, int'(updRd), int'(updRs1), updAuipcPair);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic fetchOnly(logic [31:0] pc, string tag);
    setFetch(pc); cycle(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle();
    rstN = 0;
    for (int i = 0; i < E; i++) mValid[i] = 0;
    mFifo = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R10: empty after reset
    fetchOnly(32'h100, "R10");
    fetchOnly(32'h0, "R10");

    // R4: first allocation goes to slot 0; same-cycle lookup still misses (R3)
    setFetch(32'h100); setUpd(32'h100, 32'h180, 15, 1, 0, 0, 0, 0); cycle("R3");
    fetchOnly(32'h100, "R1");
    fetchOnly(32'h0010_0100, "R2");
    fetchOnly(32'h0000_4100, "R2");
    fetchOnly(32'h0000_2100, "R2");
    fetchOnly(32'h104, "R1");
    fetchValid = 0; fetchPc = 32'h100; cycle("R1");

    // R4: fill and wrap the replacement pointer with an index equal to ENTRIES
    for (int k = 0; k < E; k++) begin
      setUpd(32'h300 + 32'(4 * k), 32'h700 + 32'(k), E, 0, 0, 0, 0, 0); cycle("R4");
    end
    fetchOnly(32'h100, "R4");
    fetchOnly(32'h31C, "R4");
    fetchOnly(32'h304, "R4");

    // R3: explicit slot overwrite
    setFetch(32'h500); setUpd(32'h500, 32'h900, 2, 0, 0, 0, 0, 0); cycle("R3");
    fetchOnly(32'h500, "R3");
    fetchOnly(32'h308, "R3");

    // R5, R7, R9: call and return through register 1
    setUpd(32'h200, 32'h400, 5, 0, 0, 1, 0, 0); cycle("R5");
    setUpd(32'h440, 32'h0, 6, 0, 1, 0, 1, 0); cycle("R5");
    fetchOnly(32'h440, "R9");
    fetchOnly(32'h200, "R7");
    fetchOnly(32'h440, "R7");
    fetchOnly(32'h440, "R9");

    // R5: register 5 as link
    setUpd(32'h200, 32'h410, 5, 0, 0, 5, 0, 0); cycle("R5");
    setUpd(32'h440, 32'h0, 6, 0, 1, 0, 5, 0); cycle("R5");
    fetchOnly(32'h200, "R5");
    fetchOnly(32'h440, "R5");
    setUpd(32'h600, 32'h800, 4, 0, 1, 1, 5, 0); cycle("R5");
    fetchOnly(32'h600, "R5");
    fetchOnly(32'h440, "R5");
    setUpd(32'h600, 32'h800, 4, 0, 1, 0, 2, 0); cycle("R5");
    fetchOnly(32'h600, "R5");
    setUpd(32'h600, 32'h800, 4, 0, 1, 5, 1, 0); cycle("R5");
    fetchOnly(32'h600, "R5");
    fetchOnly(32'h440, "R5");

    // R6: upper-immediate pair does not push
    setUpd(32'h600, 32'h840, 4, 0, 1, 1, 1, 1); cycle("R6");
    fetchOnly(32'h600, "R6");
    fetchOnly(32'h440, "R6");
    setUpd(32'h600, 32'h840, 4, 0, 1, 1, 1, 0); cycle("R6");
    fetchOnly(32'h600, "R6");
    fetchOnly(32'h440, "R6");

    // R8: overflow then drain past empty
    setUpd(32'h200, 32'h400, 5, 0, 0, 1, 0, 0); cycle("R8");
    for (int k = 0; k < DEPTH + 1; k++) fetchOnly(32'h200 | (32'(k) << 16), "R8");
    for (int k = 0; k < DEPTH + 1; k++) fetchOnly(32'h440, "R8");

    // mixed traffic against the model
    for (int n = 0; n < 800; n++) begin
      int r = $urandom;
      int regs [4] = '{0, 1, 2, 5};
      if (r[0]) setFetch(32'h1000 + 32'(4 * ((r >> 4) & 15)) + (32'((r >> 20) & 3) << 16));
      if (r[1]) setUpd(32'h1000 + 32'(4 * ((r >> 8) & 15)), 32'($urandom), (r >> 12) & 15,
                       r[2], r[3], regs[(r >> 16) & 3], regs[(r >> 18) & 3], r[22]);
      cycle("R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule